// File: doc/BRIEF.md
# Bus Security Access Filter

This block sits between one request source and a group of memory-mapped targets. Every single-beat request carries an address, a read/write flag and a security attribute bit (0 means a Secure access, 1 means a Non-secure access). The filter works out which target the request is for and whether that target may see an access of that security. A permitted request goes straight on to its target in the same cycle. A refused request is never shown to any target. It is accepted at once, and a fault response follows on the next cycle.

Each target window has a fixed policy, chosen by parameter. The policies are: Secure-only, Non-secure-only, switchable at start-up (Secure out of reset), security-aware pass-through, and partitioned. A partitioned window is checked against a table of up to nine page-granular regions, each marked Secure or Non-secure. The switch bits and the region table live in a small configuration space that has its own port. That space honours only Secure accesses.

Top module: `sec_access_filter`

## Requirements
- R1: A request to a Secure-only window (window 0 by default) is forwarded only when its security bit is 0; with the bit at 1 it is refused and no target sees it.
- R2: A request to a Non-secure-only window (window 1 by default) is forwarded only when its security bit is 1; a request with the bit at 0 is refused.
- R3: A switchable window (window 2 by default) behaves as Secure-only after reset, when the switch register at configuration offset 0x00 reads 0. After a Secure write sets the window's bit (bit 2) to 1, it behaves as Non-secure-only. Clearing the bit makes it Secure-only again.
- R4: A pass-through window (window 3 by default) forwards every request, with address, data, direction and security bit unchanged. At most one target strobe is raised in any cycle.
- R5: In a partitioned window (window 4 by default), a request whose page (address bits 31:12) lies within an enabled region's inclusive base..limit range is forwarded only when its security bit equals that region's Non-secure flag. Region r sits at configuration offset 0x10+16*r. Its base is at +0x0, its limit at +0x4, and its control word at +0x8, with bit 0 as enable and bit 1 as the Non-secure flag.
- R6: When enabled regions overlap, the lowest-numbered matching region decides.
- R7: A partitioned-window address that matches no enabled region is treated as Secure-only.
- R8: A configuration access with its security bit at 1 returns a fault, reads as zero and changes nothing. A Secure write of a base or limit whose low 12 bits are not zero also faults and changes nothing. A Secure read returns the stored page in bits 31:12, with zeros below.
- R9: A refused request raises the fault strobe exactly one cycle after it was accepted, carrying the request's address and direction. A forwarded request never raises it.
- R10: A request to a window index (address bits 31:29) that is at or above the number of targets is refused.
- R11: A refused request is accepted at once, whatever the targets' ready inputs. A permitted request is accepted only when its target's ready input is high.
- R12: A configuration write and a request in the same cycle: the request is judged on the configuration as it stood before the write, and the write applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Request byte address; bits 31:29 pick the window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_ns | input | 1 | Security bit: 0 Secure, 1 Non-secure |
| fwd_valid | output | 5 | One strobe per target, at most one high |
| fwd_ready | input | 5 | Ready from each target |
| fwd_addr | output | 32 | Forwarded address |
| fwd_write | output | 1 | Forwarded direction |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_ns | output | 1 | Forwarded security bit |
| flt_valid | output | 1 | Fault response strobe |
| flt_addr | output | 32 | Address of the refused request |
| flt_write | output | 1 | Direction of the refused request |
| cfg_valid | input | 1 | Configuration access present (always accepted) |
| cfg_write | input | 1 | 1 = configuration write |
| cfg_ns | input | 1 | Security bit of the configuration access |
| cfg_addr | input | 8 | Configuration byte offset, word aligned |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_resp_valid | output | 1 | Configuration response, one cycle after the access |
| cfg_resp_fault | output | 1 | Configuration access refused |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
Two functions can fall in the same cycle: a configuration write that retunes a region, and a data request that lands in that same region. The bench provokes this on purpose. It drives a flag change on region 5 and a Non-secure request to that region on one clock edge. It expects the refusal that the old flag dictates, then re-issues the same request and expects it to pass. The fault strobe is the second kind of overlap: it belongs to the previous request, while the next request may already be deciding. So every request's fault outcome is judged one cycle later, at the next falling edge, against the reference model.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [2:0] {
        MODE_SEC   = 3'd0,
        MODE_NSEC  = 3'd1,
        MODE_BOOT  = 3'd2,
        MODE_AWARE = 3'd3,
        MODE_PART  = 3'd4
    } slv_mode_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/sfp_cfg_regs.sv
module sfp_cfg_regs
    import sfp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NSLV   = 5,
    parameter int NREG   = 9,
    parameter int PAGE_W = 12,
    parameter int CFG_AW = 8,
    parameter logic [NSLV-1:0][MODE_W-1:0] SLV_MODE = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_valid,
    input  logic                            cfg_write,
    input  logic                            cfg_ns,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [DATA_W-1:0]               cfg_wdata,
    output logic                            cfg_resp_valid,
    output logic                            cfg_resp_fault,
    output logic [DATA_W-1:0]               cfg_rdata,
    output logic [NSLV-1:0]                 boot_ns,
    output logic [NREG-1:0]                 rg_en,
    output logic [NREG-1:0]                 rg_ns,
    output logic [NREG-1:0][ADDR_W-PAGE_W-1:0] rg_base,
    output logic [NREG-1:0][ADDR_W-PAGE_W-1:0] rg_limit
);

    localparam int PN_W  = ADDR_W - PAGE_W;
    localparam int GRP_W = CFG_AW - 4;

    typedef struct packed {
        logic [NSLV-1:0]            boot_ns;
        logic [NREG-1:0]            en;
        logic [NREG-1:0]            ns;
        logic [NREG-1:0][PN_W-1:0]  base;
        logic [NREG-1:0][PN_W-1:0]  limit;
        logic                       rsp_valid;
        logic                       rsp_fault;
        logic [DATA_W-1:0]          rdata;
    } cfg_state_t;

    cfg_state_t q, d;
    logic [NSLV-1:0] boot_mask;

    for (genvar i = 0; i < NSLV; i++) begin : g_mask
        assign boot_mask[i] = (SLV_MODE[i] == MODE_BOOT);
    end

    logic [GRP_W-1:0] grp;
    logic [1:0]       fld;
    logic             word_ok;
    logic             bad_align;

    assign grp       = cfg_addr[CFG_AW-1:4];
    assign fld       = cfg_addr[3:2];
    assign word_ok   = (cfg_addr[1:0] == 2'b00);
    assign bad_align = |cfg_wdata[PAGE_W-1:0];

    always_comb begin
        d           = q;
        d.rsp_valid = cfg_valid;
        d.rsp_fault = 1'b0;
        d.rdata     = '0;
        if (cfg_valid) begin
            if (cfg_ns) begin
                d.rsp_fault = 1'b1;
            end else if (word_ok) begin
                if (grp == '0 && fld == 2'd0) begin
                    if (cfg_write) d.boot_ns = cfg_wdata[NSLV-1:0] & boot_mask;
                    else           d.rdata   = DATA_W'(q.boot_ns);
                end
                for (int r = 0; r < NREG; r++) begin
                    if (grp == GRP_W'(r + 1)) begin
                        case (fld)
                            2'd0: begin
                                if (!cfg_write)     d.rdata     = DATA_W'({q.base[r], {PAGE_W{1'b0}}});
                                else if (bad_align) d.rsp_fault = 1'b1;
                                else                d.base[r]   = cfg_wdata[ADDR_W-1:PAGE_W];
                            end
                            2'd1: begin
                                if (!cfg_write)     d.rdata     = DATA_W'({q.limit[r], {PAGE_W{1'b0}}});
                                else if (bad_align) d.rsp_fault = 1'b1;
                                else                d.limit[r]  = cfg_wdata[ADDR_W-1:PAGE_W];
                            end
                            2'd2: begin
                                if (cfg_write) begin
                                    d.en[r] = cfg_wdata[0];
                                    d.ns[r] = cfg_wdata[1];
                                end else begin
                                    d.rdata = DATA_W'({q.ns[r], q.en[r]});
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_resp_valid = q.rsp_valid;
    assign cfg_resp_fault = q.rsp_fault;
    assign cfg_rdata      = q.rdata;
    assign boot_ns        = q.boot_ns;
    assign rg_en          = q.en;
    assign rg_ns          = q.ns;
    assign rg_base        = q.base;
    assign rg_limit       = q.limit;

endmodule

// File: rtl/sfp_region_lookup.sv
module sfp_region_lookup #(
    parameter int NREG = 9,
    parameter int PN_W = 20
) (
    input  logic [PN_W-1:0]            page,
    input  logic [NREG-1:0]            rg_en,
    input  logic [NREG-1:0]            rg_ns,
    input  logic [NREG-1:0][PN_W-1:0]  rg_base,
    input  logic [NREG-1:0][PN_W-1:0]  rg_limit,
    output logic                       hit,
    output logic                       hit_ns
);

    logic [NREG-1:0] match;

    for (genvar r = 0; r < NREG; r++) begin : g_cmp
        assign match[r] = rg_en[r] && (page >= rg_base[r]) && (page <= rg_limit[r]);
    end

    always_comb begin
        hit    = 1'b0;
        hit_ns = 1'b0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit    = 1'b1;
                hit_ns = rg_ns[r];
            end
        end
    end

endmodule

// File: rtl/sfp_access_decide.sv
module sfp_access_decide
    import sfp_pkg::*;
#(
    parameter int NSLV  = 5,
    parameter int SEL_W = 3,
    parameter logic [NSLV-1:0][MODE_W-1:0] SLV_MODE = '0
) (
    input  logic [SEL_W-1:0] win,
    input  logic             req_ns,
    input  logic [NSLV-1:0]  boot_ns,
    input  logic             rg_hit,
    input  logic             rg_hit_ns,
    output logic             allow
);

    always_comb begin
        allow = 1'b0;
        for (int i = 0; i < NSLV; i++) begin
            if (win == SEL_W'(i)) begin
                case (SLV_MODE[i])
                    MODE_SEC:   allow = !req_ns;
                    MODE_NSEC:  allow = req_ns;
                    MODE_BOOT:  allow = (req_ns == boot_ns[i]);
                    MODE_AWARE: allow = 1'b1;
                    MODE_PART:  allow = rg_hit ? (req_ns == rg_hit_ns) : !req_ns;
                    default:    allow = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter
    import sfp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NSLV   = 5,
    parameter int SEL_W  = 3,
    parameter int NREG   = 9,
    parameter int PAGE_W = 12,
    parameter int CFG_AW = 8,
    parameter logic [NSLV-1:0][MODE_W-1:0] SLV_MODE =
        {MODE_PART, MODE_AWARE, MODE_BOOT, MODE_NSEC, MODE_SEC}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_ns,
    output logic [NSLV-1:0]   fwd_valid,
    input  logic [NSLV-1:0]   fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_ns,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic              flt_write,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_ns,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_resp_valid,
    output logic              cfg_resp_fault,
    output logic [DATA_W-1:0] cfg_rdata
);

    localparam int PN_W = ADDR_W - PAGE_W;

    typedef struct packed {
        logic              flt_valid;
        logic [ADDR_W-1:0] flt_addr;
        logic              flt_write;
    } flt_state_t;

    flt_state_t q, d;

    logic [NSLV-1:0]            boot_ns;
    logic [NREG-1:0]            rg_en;
    logic [NREG-1:0]            rg_ns;
    logic [NREG-1:0][PN_W-1:0]  rg_base;
    logic [NREG-1:0][PN_W-1:0]  rg_limit;
    logic                       rg_hit;
    logic                       rg_hit_ns;
    logic                       allow;
    logic [SEL_W-1:0]           win;
    logic                       sel_ready;

    assign win = req_addr[ADDR_W-1 -: SEL_W];

    sfp_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLV(NSLV), .NREG(NREG),
        .PAGE_W(PAGE_W), .CFG_AW(CFG_AW), .SLV_MODE(SLV_MODE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_resp_valid(cfg_resp_valid), .cfg_resp_fault(cfg_resp_fault),
        .cfg_rdata(cfg_rdata),
        .boot_ns(boot_ns), .rg_en(rg_en), .rg_ns(rg_ns),
        .rg_base(rg_base), .rg_limit(rg_limit)
    );

    sfp_region_lookup #(.NREG(NREG), .PN_W(PN_W)) u_lookup (
        .page(req_addr[ADDR_W-1:PAGE_W]),
        .rg_en(rg_en), .rg_ns(rg_ns), .rg_base(rg_base), .rg_limit(rg_limit),
        .hit(rg_hit), .hit_ns(rg_hit_ns)
    );

    sfp_access_decide #(.NSLV(NSLV), .SEL_W(SEL_W), .SLV_MODE(SLV_MODE)) u_decide (
        .win(win), .req_ns(req_ns), .boot_ns(boot_ns),
        .rg_hit(rg_hit), .rg_hit_ns(rg_hit_ns), .allow(allow)
    );

    for (genvar i = 0; i < NSLV; i++) begin : g_fwd
        assign fwd_valid[i] = req_valid && allow && (win == SEL_W'(i));
    end

    always_comb begin
        sel_ready = 1'b0;
        for (int i = 0; i < NSLV; i++) begin
            if (win == SEL_W'(i)) sel_ready = fwd_ready[i];
        end
    end

    assign req_ready = allow ? sel_ready : 1'b1;
    assign fwd_addr  = req_addr;
    assign fwd_write = req_write;
    assign fwd_wdata = req_wdata;
    assign fwd_ns    = req_ns;

    always_comb begin
        d           = q;
        d.flt_valid = req_valid && !allow;
        if (req_valid && !allow) begin
            d.flt_addr  = req_addr;
            d.flt_write = req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flt_valid = q.flt_valid;
    assign flt_addr  = q.flt_addr;
    assign flt_write = q.flt_write;

endmodule

// File: rtl/sec_access_filter_chk.sv
module sec_access_filter_chk
    import sfp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NSLV   = 5,
    parameter int SEL_W  = 3,
    parameter logic [NSLV-1:0][MODE_W-1:0] SLV_MODE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ns,
    input logic [NSLV-1:0]   fwd_valid,
    input logic              flt_valid,
    input logic              cfg_valid,
    input logic              cfg_ns,
    input logic              cfg_resp_valid,
    input logic              cfg_resp_fault
);

    logic [NSLV-1:0]  sec_mask;
    logic [NSLV-1:0]  nsec_mask;
    logic [SEL_W-1:0] win;
    logic             win_aware;
    logic             win_unmapped;

    for (genvar i = 0; i < NSLV; i++) begin : g_mask
        assign sec_mask[i]  = (SLV_MODE[i] == MODE_SEC);
        assign nsec_mask[i] = (SLV_MODE[i] == MODE_NSEC);
    end

    assign win          = req_addr[ADDR_W-1 -: SEL_W];
    assign win_unmapped = ({1'b0, win} >= (SEL_W + 1)'(NSLV));

    always_comb begin
        win_aware = 1'b0;
        for (int i = 0; i < NSLV; i++) begin
            if (win == SEL_W'(i) && SLV_MODE[i] == MODE_AWARE) win_aware = 1'b1;
        end
    end

    AST_SEC_ONLY_NO_NS: assert property (@(posedge clk) disable iff (!rst_n)
        |(fwd_valid & sec_mask) |-> !req_ns); // R1
    AST_NS_ONLY_NO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        |(fwd_valid & nsec_mask) |-> req_ns); // R2
    AST_AWARE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && win_aware |-> |fwd_valid); // R4
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_valid)); // R4
    AST_CFG_NS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ns |=> cfg_resp_valid && cfg_resp_fault); // R8
    AST_FAULT_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> $past(req_valid && fwd_valid == '0)); // R9
    AST_UNMAPPED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && win_unmapped |-> fwd_valid == '0); // R10
    AST_REFUSAL_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && fwd_valid == '0 |-> req_ready); // R11

endmodule

bind sec_access_filter sec_access_filter_chk #(
    .ADDR_W(ADDR_W), .NSLV(NSLV), .SEL_W(SEL_W), .SLV_MODE(SLV_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ns(req_ns), .fwd_valid(fwd_valid),
    .flt_valid(flt_valid), .cfg_valid(cfg_valid), .cfg_ns(cfg_ns),
    .cfg_resp_valid(cfg_resp_valid), .cfg_resp_fault(cfg_resp_fault)
);

// File: tb/test_sec_access_filter.sv
module test_sec_access_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [4:0]  fwd_valid, fwd_ready = '0;
    logic [31:0] fwd_addr, fwd_wdata, flt_addr, cfg_rdata;
    logic        fwd_write, fwd_ns, flt_valid, flt_write;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0, cfg_ns = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_resp_valid, cfg_resp_fault;

    int n_chk = 0;
    int n_fail = 0;

    bit [4:0]  m_boot;
    bit        m_en [9];
    bit        m_ns [9];
    bit [19:0] m_base [9];
    bit [19:0] m_lim [9];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sec_access_filter i_sec_access_filter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_ns(req_ns),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
        .fwd_write(fwd_write), .fwd_wdata(fwd_wdata), .fwd_ns(fwd_ns),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_write(flt_write),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_resp_valid(cfg_resp_valid), .cfg_resp_fault(cfg_resp_fault),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_allow(input logic [31:0] a, input bit ns);
        case (a[31:29])
            3'd0: return !ns;
            3'd1: return ns;
            3'd2: return ns == m_boot[2];
            3'd3: return 1'b1;
            3'd4: begin
                for (int r = 0; r < 9; r++)
                    if (m_en[r] && a[31:12] >= m_base[r] && a[31:12] <= m_lim[r])
                        return ns == m_ns[r];
                return !ns;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit is_bound(input logic [7:0] a);
        return a[7:4] >= 4'd1 && a[7:4] <= 4'd9 && a[3:2] <= 2'd1 && a[1:0] == 2'b00;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int r;
        if (a == 8'h00) return {27'd0, m_boot};
        if (a[7:4] < 4'd1 || a[7:4] > 4'd9 || a[1:0] != 2'b00) return '0;
        r = int'(a[7:4]) - 1;
        case (a[3:2])
            2'd0: return {m_base[r], 12'h0};
            2'd1: return {m_lim[r], 12'h0};
            2'd2: return {30'd0, m_ns[r], m_en[r]};
            default: return '0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] v);
        int r;
        if (a == 8'h00) begin
            m_boot = v[4:0] & 5'b00100;
        end else if (a[7:4] >= 4'd1 && a[7:4] <= 4'd9 && a[1:0] == 2'b00) begin
            r = int'(a[7:4]) - 1;
            case (a[3:2])
                2'd0: m_base[r] = v[31:12];
                2'd1: m_lim[r]  = v[31:12];
                2'd2: begin m_en[r] = v[0]; m_ns[r] = v[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic do_req(input logic [31:0] a, input bit ns, input bit wr,
                          input logic [4:0] rdy, input string tag);
        bit         al = exp_allow(a, ns);
        int         w = int'(a[31:29]);
        logic [4:0] ev = al ? (5'b1 << w) : 5'b0;
        bit         er = al ? rdy[w] : 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_ns = ns; req_write = wr;
        req_wdata = $urandom; fwd_ready = rdy;
        #1;
        check(fwd_valid == ev, tag, "fwd_valid", 32'(fwd_valid), 32'(ev));
        check(req_ready == er, tag, "req_ready", 32'(req_ready), 32'(er));
        if (al) begin
            check(fwd_addr == a && fwd_ns == ns && fwd_write == wr, tag,
                  "fwd_addr", fwd_addr, a);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(flt_valid == !al, tag, "flt_valid", 32'(flt_valid), 32'(!al));
        if (!al) check(flt_addr == a && flt_write == wr, tag, "flt_addr", flt_addr, a);
    endtask

    task automatic cfg_access(input logic [7:0] a, input logic [31:0] v, input bit wr,
                              input bit ns, input string tag);
        bit          ef = ns || (wr && is_bound(a) && v[11:0] != 12'h0);
        logic [31:0] er = (ns || wr) ? 32'h0 : model_read(a);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = v; cfg_write = wr; cfg_ns = ns;
        @(posedge clk);
        #1;
        cfg_valid = 1'b0;
        if (wr && !ef) model_write(a, v);
        @(negedge clk);
        check(cfg_resp_valid && cfg_resp_fault == ef, tag, "cfg_resp_fault",
              32'(cfg_resp_fault), 32'(ef));
        if (!wr) check(cfg_rdata == er, tag, "cfg_rdata", cfg_rdata, er);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(flt_valid == 1'b0, "R9", "reset flt_valid", 32'(flt_valid), 0);
        check(fwd_valid == 5'b0, "R4", "reset fwd_valid", 32'(fwd_valid), 0);
        check(cfg_resp_valid == 1'b0, "R8", "reset cfg_resp_valid", 32'(cfg_resp_valid), 0);
        cfg_access(8'h00, 0, 1'b0, 1'b0, "R3");

        do_req(32'h0000_1000, 1'b0, 1'b0, 5'h1f, "R1");
        do_req(32'h0000_1004, 1'b1, 1'b1, 5'h1f, "R1");
        do_req(32'h2000_0010, 1'b0, 1'b1, 5'h1f, "R2");
        do_req(32'h2000_0020, 1'b1, 1'b0, 5'h1f, "R2");
        do_req(32'h4000_0000, 1'b0, 1'b0, 5'h1f, "R3");
        do_req(32'h4000_0100, 1'b1, 1'b0, 5'h1f, "R3");
        cfg_access(8'h00, 32'h4, 1'b1, 1'b1, "R8");
        do_req(32'h4000_0100, 1'b1, 1'b0, 5'h1f, "R8");
        cfg_access(8'h00, 32'h4, 1'b1, 1'b0, "R3");
        do_req(32'h4000_0200, 1'b1, 1'b1, 5'h1f, "R3");
        do_req(32'h4000_0300, 1'b0, 1'b1, 5'h1f, "R3");
        cfg_access(8'h00, 0, 1'b0, 1'b0, "R3");
        do_req(32'h6000_0040, 1'b0, 1'b1, 5'h1f, "R4");
        do_req(32'h6000_0080, 1'b1, 1'b0, 5'h1f, "R4");
        do_req(32'h8000_4000, 1'b0, 1'b0, 5'h1f, "R7");
        do_req(32'h8000_4000, 1'b1, 1'b0, 5'h1f, "R7");

        cfg_access(8'h30, 32'h8001_0000, 1'b1, 1'b0, "R5");
        cfg_access(8'h34, 32'h8001_F000, 1'b1, 1'b0, "R5");
        cfg_access(8'h38, 32'h3, 1'b1, 1'b0, "R5");
        cfg_access(8'h60, 32'h8001_8000, 1'b1, 1'b0, "R6");
        cfg_access(8'h64, 32'h8002_F000, 1'b1, 1'b0, "R6");
        cfg_access(8'h68, 32'h1, 1'b1, 1'b0, "R6");
        do_req(32'h8001_4000, 1'b1, 1'b0, 5'h1f, "R5");
        do_req(32'h8001_4000, 1'b0, 1'b0, 5'h1f, "R5");
        do_req(32'h8001_8ABC, 1'b1, 1'b1, 5'h1f, "R6");
        do_req(32'h8001_8ABC, 1'b0, 1'b1, 5'h1f, "R6");
        do_req(32'h8002_4000, 1'b0, 1'b0, 5'h1f, "R5");
        do_req(32'h8002_4000, 1'b1, 1'b0, 5'h1f, "R5");
        do_req(32'h8004_0000, 1'b1, 1'b0, 5'h1f, "R7");

        cfg_access(8'h30, 32'h8001_0010, 1'b1, 1'b0, "R8");
        cfg_access(8'h30, 0, 1'b0, 1'b0, "R8");
        cfg_access(8'h38, 0, 1'b0, 1'b1, "R8");
        cfg_access(8'h38, 0, 1'b0, 1'b0, "R8");

        do_req(32'hC000_0000, 1'b0, 1'b0, 5'h1f, "R10");
        do_req(32'hE000_0000, 1'b1, 1'b1, 5'h1f, "R10");
        do_req(32'h0000_2000, 1'b0, 1'b0, 5'h00, "R11");
        do_req(32'h0000_2000, 1'b1, 1'b0, 5'h00, "R11");

        // R12: region 5 turns Non-secure in the same cycle as a Non-secure request
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h8002_4000; req_ns = 1'b1; req_write = 1'b0;
        fwd_ready = 5'h1f;
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_ns = 1'b0; cfg_addr = 8'h68;
        cfg_wdata = 32'h3;
        #1;
        check(fwd_valid == 5'b0, "R12", "fwd_valid old config", 32'(fwd_valid), 0);
        @(posedge clk);
        #1;
        req_valid = 1'b0; cfg_valid = 1'b0;
        model_write(8'h68, 32'h3);
        @(negedge clk);
        check(flt_valid == 1'b1, "R12", "flt_valid", 32'(flt_valid), 1);
        check(cfg_resp_fault == 1'b0, "R12", "cfg_resp_fault", 32'(cfg_resp_fault), 0);
        do_req(32'h8002_4000, 1'b1, 1'b0, 5'h1f, "R12");

        for (int it = 0; it < 400; it++) begin
            if ($urandom % 8 == 0) begin
                int r = $urandom % 9;
                logic [31:0] v;
                case ($urandom % 3)
                    0: v = {3'd4, 11'd0, 6'($urandom % 64), 12'h0};
                    1: v = {3'd4, 11'd0, 6'($urandom % 64), 12'h0};
                    default: v = 32'($urandom % 4);
                endcase
                cfg_access(8'(8'h10 + 16 * r + 4 * ($urandom % 3)), v, 1'b1,
                           ($urandom % 4) == 0, "R5");
            end else begin
                logic [31:0] a = {3'($urandom % 8), 11'd0, 6'($urandom % 64), 12'($urandom)};
                do_req(a, 1'($urandom), 1'($urandom), 5'($urandom), "R6");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule